// File: doc/BRIEF.md
# Card Stream Write Data Engine

This block is the host-side engine that drives the single-bit DAT line of a memory card during a sequential (stream) write. A command/response unit pulses `rsp_done_i` once the card's response to the stream write command has arrived. The engine then waits a programmable number of clock cycles and drives a low start bit. After that it serialises bytes taken from a valid/ready byte input, most significant bit first and one bit per clock. The stream has no block framing, no checksum and no status token. If the byte source runs dry, the engine fills the line with high bits until a byte or a stop request arrives.

When the host asks to stop, the byte already accepted is finished, one high end bit is driven and the line is released. The engine ignores the line for a short settling window. It then waits for the card to release its busy indication (DAT held low while the card programs). It reports completion with a one-cycle done pulse. If the card stays busy too long, it raises a sticky timeout flag instead.

Top module: `strm_wr_engine`

## Requirements
- R1: While reset is asserted and after its release, DAT is not driven (`dat_oe_o`=0), and `byte_ready_o`, `busy_o`, `done_o` and `timeout_o` are all 0.
- R2: A `rsp_done_i` sampled high while idle makes `busy_o` high from the next cycle. The start bit (DAT driven low) appears exactly `gap_cycles_i`+1 cycles after that sampling cycle. A gap value of 0 puts the start bit in the very next cycle.
- R3: `rsp_done_i` has no effect while the engine is busy.
- R4: Each accepted byte is driven on DAT as 8 consecutive bits, MSB first, directly after the start bit or the previous byte, with no extra bits between bytes.
- R5: `byte_ready_o` is high only in the start-bit cycle, in the last bit of a byte and in fill cycles, and only while no stop is pending. `byte_valid_i` outside those cycles is ignored.
- R6: When a byte is needed and none is valid, the engine drives DAT high (fill) with `byte_ready_o` high until a byte is accepted or a stop arrives.
- R7: After a stop request, the byte in flight completes, one high end bit follows, and DAT is then released. A stop raised before any byte gives an end bit right after the start bit.
- R8: For 2 cycles after DAT is released, the DAT input is ignored and `busy_o` stays high.
- R9: After the settling window, the engine samples DAT each cycle. In the cycle after DAT is sampled high, `busy_o` is 0 and `done_o` is high for exactly one cycle.
- R10: With a non-zero `busy_limit_i` L, L consecutive low samples end the busy wait. This sets `timeout_o`, clears `busy_o` and gives no done pulse. `timeout_o` stays set until the next accepted `rsp_done_i`. A limit of 0 disables the timeout.
- R11: DAT is never driven while idle, during the gap, during settling or while waiting for busy release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rsp_done_i | input | 1 | Pulse: card response to the stream write command received |
| gap_cycles_i | input | GAP_W | Cycles between response and start bit |
| busy_limit_i | input | TO_W | Busy-wait limit in cycles, 0 disables |
| byte_data_i | input | BYTE_W | Byte to send |
| byte_valid_i | input | 1 | Byte input valid |
| byte_ready_o | output | 1 | Byte input ready |
| stop_req_i | input | 1 | Pulse: host stop command issued |
| dat_oe_o | output | 1 | DAT output enable |
| dat_out_o | output | 1 | DAT output value |
| dat_in_i | input | 1 | DAT line as seen by the host |
| busy_o | output | 1 | Engine active |
| done_o | output | 1 | One-cycle pulse at busy release |
| timeout_o | output | 1 | Sticky busy-timeout error |

## Verification
On every cycle, the assertions check several properties of the line and the handshake. The first bit driven after a release is low, and the last bit before a release is high. Ready never appears while DAT is undriven, and an unanswered ready slot turns into a high fill bit. Done is a single-cycle pulse, and a timeout never coincides with done or busy. The bench scenarios are needed to show the things that depend on counting: the exact gap length, the bit order and contiguity of the bytes, which byte is the last one sent after a stop, the length of the settling window, and the busy-limit boundary. They also show that the timeout flag is held until the next start.

// File: rtl/strm_wr_pkg.sv
package strm_wr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_GAP   = 3'd1,
        ST_START = 3'd2,
        ST_DATA  = 3'd3,
        ST_HOLD  = 3'd4,
        ST_END   = 3'd5,
        ST_WAIT  = 3'd6
    } eng_state_e;

    typedef enum logic [1:0] {
        MON_OFF    = 2'd0,
        MON_SETTLE = 2'd1,
        MON_WATCH  = 2'd2
    } mon_phase_e;

endpackage

// File: rtl/strm_wr_shifter.sv
module strm_wr_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              shift_i,
    output logic              bit_o,
    output logic              last_o
);
    localparam int CNT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic [BYTE_W-1:0] sreg;
        logic [CNT_W-1:0]  idx;
    } shf_regs_t;

    shf_regs_t shf_d, shf_q;

    always_comb begin
        shf_d = shf_q;
        if (load_i) begin
            shf_d.sreg = data_i;
            shf_d.idx  = '0;
        end else if (shift_i) begin
            shf_d.sreg = {shf_q.sreg[BYTE_W-2:0], 1'b0};
            shf_d.idx  = shf_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    assign bit_o  = shf_q.sreg[BYTE_W-1];
    assign last_o = (shf_q.idx == LAST_IDX);
endmodule

// File: rtl/strm_wr_busy_mon.sv
module strm_wr_busy_mon
    import strm_wr_pkg::*;
#(
    parameter int TO_W       = 16,
    parameter int SETTLE_CYC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            dat_i,
    input  logic [TO_W-1:0] limit_i,
    output logic            release_o,
    output logic            expire_o
);
    localparam int SET_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYC - 1);

    typedef struct packed {
        mon_phase_e      ph;
        logic [SET_W-1:0] scnt;
        logic [TO_W-1:0]  tcnt;
    } mon_regs_t;

    mon_regs_t mon_d, mon_q;
    logic      watching;
    logic      limit_on;

    assign watching  = (mon_q.ph == MON_WATCH);
    assign limit_on  = (limit_i != '0);
    assign release_o = watching && dat_i;
    assign expire_o  = watching && !dat_i && limit_on
                       && (mon_q.tcnt == (limit_i - 1'b1));

    always_comb begin
        mon_d = mon_q;
        unique case (mon_q.ph)
            MON_OFF: begin
                if (start_i) begin
                    mon_d.ph   = MON_SETTLE;
                    mon_d.scnt = '0;
                end
            end
            MON_SETTLE: begin
                if (mon_q.scnt == SET_LAST) begin
                    mon_d.ph   = MON_WATCH;
                    mon_d.tcnt = '0;
                end else begin
                    mon_d.scnt = mon_q.scnt + 1'b1;
                end
            end
            MON_WATCH: begin
                if (release_o || expire_o) mon_d.ph = MON_OFF;
                else                       mon_d.tcnt = mon_q.tcnt + 1'b1;
            end
            default: mon_d.ph = MON_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mon_q <= '0;
        else        mon_q <= mon_d;
    end
endmodule

// File: rtl/strm_wr_engine.sv
module strm_wr_engine
    import strm_wr_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int GAP_W      = 8,
    parameter int TO_W       = 16,
    parameter int SETTLE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsp_done_i,
    input  logic [GAP_W-1:0]  gap_cycles_i,
    input  logic [TO_W-1:0]   busy_limit_i,
    input  logic [BYTE_W-1:0] byte_data_i,
    input  logic              byte_valid_i,
    output logic              byte_ready_o,
    input  logic              stop_req_i,
    output logic              dat_oe_o,
    output logic              dat_out_o,
    input  logic              dat_in_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              timeout_o
);
    localparam logic [GAP_W-1:0] GAP_ONE = GAP_W'(1);

    typedef struct packed {
        eng_state_e       st;
        logic [GAP_W-1:0] gap;
        logic             stop_pend;
        logic             done;
        logic             tout;
    } eng_regs_t;

    eng_regs_t eng_d, eng_q;

    logic sh_load, sh_shift, sh_bit, sh_last;
    logic mon_start, mon_release, mon_expire;
    logic slot, ready, hs, stop_any, streaming;

    strm_wr_shifter #(.BYTE_W(BYTE_W)) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (sh_load),
        .data_i  (byte_data_i),
        .shift_i (sh_shift),
        .bit_o   (sh_bit),
        .last_o  (sh_last)
    );

    strm_wr_busy_mon #(.TO_W(TO_W), .SETTLE_CYC(SETTLE_CYC)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (mon_start),
        .dat_i     (dat_in_i),
        .limit_i   (busy_limit_i),
        .release_o (mon_release),
        .expire_o  (mon_expire)
    );

    assign slot      = (eng_q.st == ST_START) || (eng_q.st == ST_HOLD)
                       || ((eng_q.st == ST_DATA) && sh_last);
    assign ready     = slot && !eng_q.stop_pend;
    assign hs        = ready && byte_valid_i;
    assign stop_any  = eng_q.stop_pend || stop_req_i;
    assign streaming = (eng_q.st == ST_GAP) || (eng_q.st == ST_START)
                       || (eng_q.st == ST_DATA) || (eng_q.st == ST_HOLD);
    assign sh_load   = hs;
    assign sh_shift  = (eng_q.st == ST_DATA) && !sh_last;
    assign mon_start = (eng_q.st == ST_END);

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        if (streaming && stop_req_i) eng_d.stop_pend = 1'b1;
        unique case (eng_q.st)
            ST_IDLE: begin
                if (rsp_done_i) begin
                    eng_d.tout      = 1'b0;
                    eng_d.stop_pend = 1'b0;
                    eng_d.gap       = gap_cycles_i;
                    eng_d.st        = (gap_cycles_i == '0) ? ST_START : ST_GAP;
                end
            end
            ST_GAP: begin
                if (eng_q.gap == GAP_ONE) eng_d.st = ST_START;
                else                      eng_d.gap = eng_q.gap - 1'b1;
            end
            ST_START, ST_HOLD: begin
                if (hs)            eng_d.st = ST_DATA;
                else if (stop_any) eng_d.st = ST_END;
                else               eng_d.st = ST_HOLD;
            end
            ST_DATA: begin
                if (sh_last) begin
                    if (hs)            eng_d.st = ST_DATA;
                    else if (stop_any) eng_d.st = ST_END;
                    else               eng_d.st = ST_HOLD;
                end
            end
            ST_END: eng_d.st = ST_WAIT;
            ST_WAIT: begin
                if (mon_release) begin
                    eng_d.st   = ST_IDLE;
                    eng_d.done = 1'b1;
                end else if (mon_expire) begin
                    eng_d.st   = ST_IDLE;
                    eng_d.tout = 1'b1;
                end
            end
            default: eng_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign byte_ready_o = ready;
    assign dat_oe_o     = (eng_q.st == ST_START) || (eng_q.st == ST_DATA)
                          || (eng_q.st == ST_HOLD) || (eng_q.st == ST_END);
    assign dat_out_o    = (eng_q.st == ST_START) ? 1'b0 :
                          (eng_q.st == ST_DATA)  ? sh_bit : 1'b1;
    assign busy_o       = (eng_q.st != ST_IDLE);
    assign done_o       = eng_q.done;
    assign timeout_o    = eng_q.tout;
endmodule

// File: rtl/strm_wr_engine_chk.sv
module strm_wr_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic stop_req_i,
    input logic byte_valid_i,
    input logic byte_ready_o,
    input logic dat_oe_o,
    input logic dat_out_o,
    input logic busy_o,
    input logic done_o,
    input logic timeout_o
);
    assert_idle_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !dat_oe_o);

    assert_first_bit_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dat_oe_o) |-> !dat_out_o);

    assert_ready_on_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready_o |-> (dat_oe_o && busy_o));

    assert_accept_then_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ready_o && byte_valid_i) |=> dat_oe_o);

    assert_fill_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ready_o && !byte_valid_i && !stop_req_i) |=> (dat_oe_o && dat_out_o));

    assert_end_bit_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dat_oe_o) |-> $past(dat_out_o));

    assert_settle_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dat_oe_o) |-> busy_o ##1 busy_o);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    assert_timeout_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> (!busy_o && !done_o));
endmodule

bind strm_wr_engine strm_wr_engine_chk u_chk (.*);

// File: tb/sim_strm_wr_engine.sv
`timescale 1ns/1ps
module sim_strm_wr_engine;
    localparam int GAP_W = 8;
    localparam int TO_W  = 16;

    typedef struct packed {
        logic       rsp;
        logic       valid;
        logic [7:0] data;
        logic       stop;
        logic       din;
    } stim_t;

    typedef struct packed {
        logic oe;
        logic out;
        logic rdy;
        logic busy;
        logic done;
        logic tout;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rsp_done_i = 1'b0;
    logic [GAP_W-1:0] gap_cycles_i = '0;
    logic [TO_W-1:0]  busy_limit_i = '0;
    logic [7:0]       byte_data_i = '0;
    logic             byte_valid_i = 1'b0;
    logic             byte_ready_o;
    logic             stop_req_i = 1'b0;
    logic             dat_oe_o, dat_out_o;
    logic             dat_in_i = 1'b1;
    logic             busy_o, done_o, timeout_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    bit cur_to = 0;

    stim_t      sq[$];
    exp_t       eq[$];
    string      tq[$];
    logic [7:0] bq[$];
    int         gq[$];

    always #2 clk = ~clk;

    strm_wr_engine #(.BYTE_W(8), .GAP_W(GAP_W), .TO_W(TO_W), .SETTLE_CYC(2)) u0 (
        .clk(clk), .rst_n(rst_n), .rsp_done_i(rsp_done_i),
        .gap_cycles_i(gap_cycles_i), .busy_limit_i(busy_limit_i),
        .byte_data_i(byte_data_i), .byte_valid_i(byte_valid_i),
        .byte_ready_o(byte_ready_o), .stop_req_i(stop_req_i),
        .dat_oe_o(dat_oe_o), .dat_out_o(dat_out_o), .dat_in_i(dat_in_i),
        .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o)
    );

    function automatic stim_t ms(logic rsp, logic valid, logic [7:0] data, logic stop, logic din);
        stim_t s;
        s.rsp = rsp; s.valid = valid; s.data = data; s.stop = stop; s.din = din;
        return s;
    endfunction

    function automatic exp_t me(logic oe, logic out, logic rdy, logic busy, logic done, logic tout);
        exp_t e;
        e.oe = oe; e.out = out; e.rdy = rdy; e.busy = busy; e.done = done; e.tout = tout;
        return e;
    endfunction

    task automatic push(stim_t s, exp_t e, string tag);
        sq.push_back(s);
        eq.push_back(e);
        tq.push_back(tag);
    endtask

    task automatic check_now(exp_t e, string tag);
        bit bad;
        checks++;
        bad = (dat_oe_o !== e.oe) || (byte_ready_o !== e.rdy) || (busy_o !== e.busy)
              || (done_o !== e.done) || (timeout_o !== e.tout)
              || (e.oe && (dat_out_o !== e.out));
        if (bad) begin
            errors++;
            $display("FAIL %s t=%0t oe,out,rdy,busy,done,to actual=%b%b%b%b%b%b expected=%b%b%b%b%b%b",
                     tag, $time, dat_oe_o, dat_out_o, byte_ready_o, busy_o, done_o, timeout_o,
                     e.oe, e.out, e.rdy, e.busy, e.done, e.tout);
        end
    endtask

    // Reference: builds the per-cycle stimulus and expected outputs of one stream
    task automatic gen(int n, int h, int b, int l);
        bit         to;
        int         lows;
        logic       cur_out;
        string      cur_tag;
        bit         stop_in_gap;
        stop_in_gap = (bq.size() == 0);
        push(ms(1, 0, 8'h00, 0, 1), me(0, 1, 0, 0, 0, cur_to), "R2");
        for (int i = 0; i < n; i++)
            push(ms(i == 0, 1, 8'hFF, stop_in_gap && (i == 0), 1),
                 me(0, 1, 0, 1, 0, 0), (i == 0) ? "R3" : "R2");
        cur_out = 1'b0;
        cur_tag = "R2";
        for (int k = 0; k < bq.size(); k++) begin
            if (gq[k] == 0) begin
                push(ms(0, 1, bq[k], 0, 1), me(1, cur_out, 1, 1, 0, 0), cur_tag);
            end else begin
                push(ms(0, 0, 8'h00, 0, 1), me(1, cur_out, 1, 1, 0, 0), cur_tag);
                for (int j = 0; j < gq[k]; j++)
                    push(ms(0, j == gq[k] - 1, bq[k], 0, 1), me(1, 1, 1, 1, 0, 0), "R6");
            end
            for (int bi = 7; bi >= 1; bi--)
                push(ms(0, 0, 8'h00, (k == bq.size() - 1) && (bi == 7) && (h == 0), 1),
                     me(1, bq[k][bi], 0, 1, 0, 0), "R4");
            cur_out = bq[k][0];
            cur_tag = "R4";
        end
        if (bq.size() == 0 || h == 0) begin
            push(ms(0, 1, 8'h3C, 0, 1), me(1, cur_out, 0, 1, 0, 0), "R7");
        end else begin
            push(ms(0, 0, 8'h00, 0, 1), me(1, cur_out, 1, 1, 0, 0), cur_tag);
            for (int j = 0; j < h; j++)
                push(ms(0, 0, 8'h00, j == h - 1, 1), me(1, 1, 1, 1, 0, 0), "R6");
        end
        push(ms(0, 1, 8'hAA, 0, 1), me(1, 1, 0, 1, 0, 0), "R7");
        push(ms(0, 0, 8'h00, 0, 1), me(0, 1, 0, 1, 0, 0), "R8");
        push(ms(0, 0, 8'h00, 0, 1), me(0, 1, 0, 1, 0, 0), "R8");
        to   = (l > 0) && (b >= l);
        lows = to ? l : b;
        for (int j = 0; j < lows; j++)
            push(ms(0, 0, 8'h00, 0, 0), me(0, 1, 0, 1, 0, 0), to ? "R10" : "R9");
        if (!to) push(ms(0, 0, 8'h00, 0, 1), me(0, 1, 0, 1, 0, 0), "R9");
        cur_to = to;
        push(ms(0, 0, 8'h00, 0, 1), me(0, 1, 0, 0, !to, to), to ? "R10" : "R9");
        push(ms(0, 0, 8'h00, 0, 1), me(0, 1, 0, 0, 0, to), to ? "R10" : "R9");
    endtask

    task automatic run_queue();
        stim_t s;
        exp_t  e;
        string t;
        while (sq.size() > 0) begin
            @(negedge clk);
            s = sq.pop_front();
            e = eq.pop_front();
            t = tq.pop_front();
            rsp_done_i   = s.rsp;
            byte_valid_i = s.valid;
            byte_data_i  = s.data;
            stop_req_i   = s.stop;
            dat_in_i     = s.din;
            check_now(e, t);
        end
    endtask

    task automatic scenario(int n, int h, int b, int l);
        gap_cycles_i = GAP_W'(n);
        busy_limit_i = TO_W'(l);
        gen(n, h, b, l);
        run_queue();
        bq.delete();
        gq.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_now(me(0, 1, 0, 0, 0, 0), "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_now(me(0, 1, 0, 0, 0, 0), "R1 after reset");

        // R2 R3 R4 R5 R7 R9: two bytes back to back, stop during last byte, no limit
        bq = '{8'hA5, 8'h3C}; gq = '{0, 0};
        scenario(3, 0, 4, 0);
        // R2 zero gap, R6 fill after last byte then stop, immediate release
        bq = '{8'h81}; gq = '{0};
        scenario(0, 2, 0, 10);
        // R7 stop before any byte, R10 timeout at the limit
        scenario(5, 0, 20, 6);
        // R6 fill before first and third byte, R10 cleared by new start, one below limit
        bq = '{8'hFF, 8'h00, 8'h7E}; gq = '{1, 0, 2};
        scenario(1, 0, 2, 3);
        // R10 limit 0 disables the timeout over a long busy
        bq = '{8'h5A}; gq = '{0};
        scenario(2, 0, 300, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule